// File: doc/BRIEF.md
# Flash Erase Command Controller

This block sits between an external device programmer and an on-chip flash array model. The array has two regions. The primary region starts at address 0000h. The secondary region is aligned to the top of the 16-bit address space. The programmer presents a 2-bit upper mode field, a 2-bit lower mode field and a 16-bit address, then pulls the program strobe low. The falling edge passes through a two-flop synchronizer, and the block then latches and decodes the command. It supports four commands: signature read, whole-array erase, region erase and sector erase. It applies a lock bit for each region and runs the erase one byte per clock. While the erase runs, a busy output stays high.

Reads do not need a strobe. The read data output follows the address and the mode fields combinationally. It shows the array contents, or the signature bytes when the mode fields select the signature read. Lock bits can only be set, through a small write port. Only a whole-array erase clears them.

Region sizes and sector sizes are parameters. Full-size operation is a 16 KB primary region and a 4 KB secondary region at F000h–FFFFh (PRI_AW = 14, SEC_AW = 12). The defaults are smaller, so the array model stays compact.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, busy and err are low, both lock bits are clear and every array byte reads 00h.
- R2: A command starts only on a high-to-low transition of prog_n. The transition is sampled by two flops. If prog_n is first seen low at rising edge k, the command is accepted at edge k+2, and busy is high from that edge on.
- R3: The command code is {mode_hi, mode_lo}. 00/00 is signature read, 00/01 is whole-array erase, 11/01 is region erase and 10/11 is sector erase. A strobe with the signature-read code starts nothing.
- R4: While {mode_hi, mode_lo} = 00/00, rd_data combinationally shows BFh at address 0030h, E4h at 0031h, and 00h at any other address.
- R5: With any other mode code, rd_data combinationally shows the array byte. Primary byte n is at address n, for n < 2^PRI_AW. Secondary byte n is at address 10000h − 2^SEC_AW + n. Unmapped addresses read 00h, and erased bytes read FFh.
- R6: Whole-array erase sets every byte of both regions to FFh even when locks are set, and clears both lock bits.
- R7: Region erase targets the primary region when address bit 15 is 0. It targets the secondary region when address bits 15 down to SEC_AW are all ones.
- R8: Sector erase sets the aligned sector containing the address to FFh. A sector is 2^PRI_SECT_W bytes in the primary region and 2^SEC_SECT_W bytes in the secondary region.
- R9: lock_set_en ORs lock_set into the lock bits, where bit 0 locks the primary region and bit 1 the secondary. A region or sector erase aimed at a locked region changes no byte, leaves busy low, and raises err for exactly one cycle at the accept edge.
- R10: A strobe is ignored without any state change if it arrives while busy, if it carries an unlisted code, or if it is a region or sector erase whose address maps to no region.
- R11: Busy stays high for exactly as many cycles as bytes erased: the region size, the sector size, or the sum of both region sizes for whole-array erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Program strobe, active low, asynchronous |
| mode_hi | input | 2 | Upper command mode field |
| mode_lo | input | 2 | Lower command mode field |
| addr | input | 16 | Command and read address |
| lock_set_en | input | 1 | Lock write enable |
| lock_set | input | 2 | Lock bits to set (bit 0 primary, bit 1 secondary) |
| rd_data | output | 8 | Combinational read data |
| busy | output | 1 | Erase in progress |
| err | output | 1 | One-cycle pulse on a refused erase |

## Verification
The bench builds the block with a 512-byte primary region, a 256-byte secondary region at FF00h, and sectors of 128 and 64 bytes. This makes the whole array readable in one sweep, and a whole-array erase takes 768 busy cycles. At these sizes a single run can reach every sector boundary, both region edges, unmapped holes between and above the regions, strobes that arrive mid-erase, and erases refused by a lock. Each case is followed by full-array comparisons against the reference model.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_CHIP   = 2'd1,
    OP_REGION = 2'd2,
    OP_SECTOR = 2'd3
  } op_e;

  // command codes, {mode_hi, mode_lo}
  localparam logic [3:0] CODE_SIG    = 4'b0000;
  localparam logic [3:0] CODE_CHIP   = 4'b0001;
  localparam logic [3:0] CODE_REGION = 4'b1101;
  localparam logic [3:0] CODE_SECTOR = 4'b1011;

  localparam logic [15:0] SIG_ADDR_MFR = 16'h0030;
  localparam logic [15:0] SIG_ADDR_DEV = 16'h0031;
  localparam logic [7:0]  SIG_MFR      = 8'hBF;
  localparam logic [7:0]  SIG_DEV      = 8'hE4;
  localparam logic [7:0]  BYTE_ERASED  = 8'hFF;
  localparam logic [7:0]  BYTE_BLANK   = 8'h00;

endpackage

// File: rtl/fec_strobe_sync.sv
module fec_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic fall
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= prog_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall = s3_q & ~s2_q;

endmodule

// File: rtl/fec_decode.sv
module fec_decode
  import fec_pkg::*;
#(
  parameter int PRI_AW     = 10,
  parameter int SEC_AW     = 9,
  parameter int PRI_SECT_W = 7,
  parameter int SEC_SECT_W = 6,
  parameter int IW         = 11,
  parameter int LW         = 11
) (
  input  logic [1:0]    mode_hi,
  input  logic [1:0]    mode_lo,
  input  logic [15:0]   addr,
  output op_e           op,
  output logic          tgt_sec,
  output logic [IW-1:0] start,
  output logic [LW-1:0] len
);

  localparam int PRI_BYTES  = 1 << PRI_AW;
  localparam int SEC_BYTES  = 1 << SEC_AW;
  localparam int ALL_BYTES  = PRI_BYTES + SEC_BYTES;
  localparam int PRI_SECT_B = 1 << PRI_SECT_W;
  localparam int SEC_SECT_B = 1 << SEC_SECT_W;

  logic pri_hit, sec_hit;

  always_comb begin
    pri_hit = (addr[15:PRI_AW] == '0);
    sec_hit = &addr[15:SEC_AW];
  end

  always_comb begin
    op      = OP_NONE;
    tgt_sec = 1'b0;
    start   = '0;
    len     = '0;
    unique case ({mode_hi, mode_lo})
      CODE_CHIP: begin
        op  = OP_CHIP;
        len = LW'(ALL_BYTES);
      end
      CODE_REGION: begin
        if (!addr[15]) begin
          op  = OP_REGION;
          len = LW'(PRI_BYTES);
        end else if (sec_hit) begin
          op      = OP_REGION;
          tgt_sec = 1'b1;
          start   = IW'(PRI_BYTES);
          len     = LW'(SEC_BYTES);
        end
      end
      CODE_SECTOR: begin
        if (pri_hit) begin
          op    = OP_SECTOR;
          start = IW'({addr[PRI_AW-1:PRI_SECT_W], {PRI_SECT_W{1'b0}}});
          len   = LW'(PRI_SECT_B);
        end else if (sec_hit) begin
          op      = OP_SECTOR;
          tgt_sec = 1'b1;
          start   = IW'(PRI_BYTES)
                  + IW'({addr[SEC_AW-1:SEC_SECT_W], {SEC_SECT_W{1'b0}}});
          len     = LW'(SEC_SECT_B);
        end
      end
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/fec_erase_seq.sv
module fec_erase_seq
  import fec_pkg::*;
#(
  parameter int IW = 11,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  op_e           op,
  input  logic          tgt_sec,
  input  logic [IW-1:0] start,
  input  logic [LW-1:0] len,
  input  logic          lock_set_en,
  input  logic [1:0]    lock_set,
  output logic          busy,
  output logic          err,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx
);

  logic          busy_q, busy_d;
  logic          err_q, err_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [1:0]    lock_q, lock_d;
  logic          run_en, lock_en, accept;

  assign accept  = fall & ~busy_q & (op != OP_NONE);
  assign run_en  = busy_q | accept;
  assign lock_en = lock_set_en | (accept & (op == OP_CHIP));

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    rem_d  = rem_q;
    lock_d = lock_q;
    err_d  = 1'b0;
    wr_en  = 1'b0;
    wr_idx = ptr_q;
    if (busy_q) begin
      wr_en = 1'b1;
      ptr_d = ptr_q + IW'(1);
      if (rem_q == '0) busy_d = 1'b0;
      else             rem_d  = rem_q - LW'(1);
    end else if (accept) begin
      if (op == OP_CHIP) begin
        busy_d = 1'b1;
        ptr_d  = start;
        rem_d  = len - LW'(1);
        lock_d = 2'b00;
      end else if (lock_q[tgt_sec]) begin
        err_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        ptr_d  = start;
        rem_d  = len - LW'(1);
      end
    end
    if (lock_set_en) lock_d = lock_d | lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      rem_q  <= '0;
    end else if (run_en) begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 2'b00;
    else if (lock_en) lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign busy = busy_q;
  assign err  = err_q;

endmodule

// File: rtl/fec_array.sv
module fec_array
  import fec_pkg::*;
#(
  parameter int PRI_AW = 10,
  parameter int SEC_AW = 9,
  parameter int IW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          sig_mode,
  input  logic [15:0]   addr,
  output logic [7:0]    rd_data
);

  localparam int PRI_BYTES = 1 << PRI_AW;
  localparam int SEC_BYTES = 1 << SEC_AW;
  localparam int ALL_BYTES = PRI_BYTES + SEC_BYTES;

  logic [7:0] mem [ALL_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ALL_BYTES; i++) mem[i] <= BYTE_BLANK;
    end else if (wr_en) begin
      mem[wr_idx] <= BYTE_ERASED;
    end
  end

  logic          pri_hit, sec_hit;
  logic [IW-1:0] rd_idx;

  always_comb begin
    pri_hit = (addr[15:PRI_AW] == '0);
    sec_hit = &addr[15:SEC_AW];
    rd_idx  = sec_hit ? IW'(PRI_BYTES) + IW'(addr[SEC_AW-1:0])
                      : IW'(addr[PRI_AW-1:0]);
    if (sig_mode) begin
      if (addr == SIG_ADDR_MFR)      rd_data = SIG_MFR;
      else if (addr == SIG_ADDR_DEV) rd_data = SIG_DEV;
      else                           rd_data = BYTE_BLANK;
    end else if (pri_hit || sec_hit) begin
      rd_data = mem[rd_idx];
    end else begin
      rd_data = BYTE_BLANK;
    end
  end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int PRI_AW     = 10,
  parameter int SEC_AW     = 9,
  parameter int PRI_SECT_W = 7,
  parameter int SEC_SECT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_n,
  input  logic [1:0]  mode_hi,
  input  logic [1:0]  mode_lo,
  input  logic [15:0] addr,
  input  logic        lock_set_en,
  input  logic [1:0]  lock_set,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        err
);

  localparam int ALL_BYTES = (1 << PRI_AW) + (1 << SEC_AW);
  localparam int IW        = $clog2(ALL_BYTES);
  localparam int LW        = $clog2(ALL_BYTES + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  logic          strobe_fall;
  op_e           dec_op;
  logic          dec_sec;
  logic [IW-1:0] dec_start;
  logic [LW-1:0] dec_len;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic          sig_mode;

  assign sig_mode = ({mode_hi, mode_lo} == CODE_SIG);

  fec_strobe_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .prog_n (prog_n),
    .fall   (strobe_fall)
  );

  fec_decode #(
    .PRI_AW(PRI_AW), .SEC_AW(SEC_AW),
    .PRI_SECT_W(PRI_SECT_W), .SEC_SECT_W(SEC_SECT_W),
    .IW(IW), .LW(LW)
  ) u_dec (
    .mode_hi (mode_hi),
    .mode_lo (mode_lo),
    .addr    (addr),
    .op      (dec_op),
    .tgt_sec (dec_sec),
    .start   (dec_start),
    .len     (dec_len)
  );

  fec_erase_seq #(.IW(IW), .LW(LW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .fall        (strobe_fall),
    .op          (dec_op),
    .tgt_sec     (dec_sec),
    .start       (dec_start),
    .len         (dec_len),
    .lock_set_en (lock_set_en),
    .lock_set    (lock_set),
    .busy        (busy),
    .err         (err),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
  );

  fec_array #(.PRI_AW(PRI_AW), .SEC_AW(SEC_AW), .IW(IW)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .sig_mode (sig_mode),
    .addr     (addr),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
  parameter int PRI_AW     = 10,
  parameter int SEC_AW     = 9,
  parameter int PRI_SECT_W = 7,
  parameter int SEC_SECT_W = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        err,
  input logic        fall,
  input logic [1:0]  mode_hi,
  input logic [1:0]  mode_lo,
  input logic [15:0] addr,
  input logic [7:0]  rd_data
);

  localparam int PRI_B = 1 << PRI_AW;
  localparam int SEC_B = 1 << SEC_AW;

  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R9: refusal pulse lasts one cycle
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R9: a refused erase leaves busy low
  a_r9_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  // R2: busy only rises at the edge after a synchronized strobe fall
  a_r2_busy_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall));

  // R9: err only follows a synchronized strobe fall
  a_r9_err_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(fall));

  // R11: each busy run matches one of the erase sizes
  a_r11_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PRI_B || run_len == SEC_B
                     || run_len == PRI_B + SEC_B
                     || run_len == (1 << PRI_SECT_W)
                     || run_len == (1 << SEC_SECT_W)));

  // R4: signature manufacturer byte
  a_r4_sig_mfr: assert property (@(posedge clk) disable iff (!rst_n)
    ({mode_hi, mode_lo} == 4'b0000 && addr == 16'h0030) |-> rd_data == 8'hBF);

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(
  .PRI_AW(PRI_AW), .SEC_AW(SEC_AW),
  .PRI_SECT_W(PRI_SECT_W), .SEC_SECT_W(SEC_SECT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .err     (err),
  .fall    (strobe_fall),
  .mode_hi (mode_hi),
  .mode_lo (mode_lo),
  .addr    (addr),
  .rd_data (rd_data)
);

// File: tb/test_flash_erase_ctrl.sv
`timescale 1ns/100ps
module test_flash_erase_ctrl;

  localparam int PAW = 9, SAW = 8, PSW = 7, SSW = 6;
  localparam int PRI = 1 << PAW, SEC = 1 << SAW, TOT = PRI + SEC;
  localparam int SEC_BASE = 65536 - SEC;

  logic        clk = 1'b0;
  logic        rst_n, prog_n, lock_set_en;
  logic [1:0]  mode_hi, mode_lo, lock_set;
  logic [15:0] addr;
  logic [7:0]  rd_data;
  logic        busy, err;

  always #2.5 clk = ~clk;

  flash_erase_ctrl #(.PRI_AW(PAW), .SEC_AW(SAW), .PRI_SECT_W(PSW), .SEC_SECT_W(SSW))
  i_flash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .addr(addr), .lock_set_en(lock_set_en), .lock_set(lock_set),
    .rd_data(rd_data), .busy(busy), .err(err)
  );

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  // ---------------- reference model ----------------
  logic [7:0] mm [TOT];
  int  pend[$];
  bit  mlock [2];
  bit  merr;
  bit  ms1, ms2, ms3;

  function automatic logic [7:0] mrd(logic [15:0] a, logic [1:0] h, logic [1:0] l);
    int ai = int'(a);
    if (h == 2'b00 && l == 2'b00) begin
      if (ai == 48) return 8'hBF;
      if (ai == 49) return 8'hE4;
      return 8'h00;
    end
    if (ai < PRI) return mm[ai];
    if (ai >= SEC_BASE) return mm[PRI + ai - SEC_BASE];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) mm[i] = 8'h00;
      pend.delete();
      mlock[0] = 0; mlock[1] = 0;
      merr = 0; ms1 = 1; ms2 = 1; ms3 = 1;
    end else begin
      bit fl;
      int a, tgt, base, sz;
      fl = ms3 & ~ms2;
      ms3 = ms2; ms2 = ms1; ms1 = prog_n;
      merr = 0;
      a = int'(addr);
      if (pend.size() > 0) begin
        mm[pend.pop_front()] = 8'hFF;
      end else if (fl) begin
        tgt = -1; base = 0; sz = 0;
        case ({mode_hi, mode_lo})
          4'b0001: begin
            for (int i = 0; i < TOT; i++) pend.push_back(i);
            mlock[0] = 0; mlock[1] = 0;
          end
          4'b1101: begin
            if (a < 32768) begin tgt = 0; base = 0; sz = PRI; end
            else if (a >= SEC_BASE) begin tgt = 1; base = PRI; sz = SEC; end
          end
          4'b1011: begin
            if (a < PRI) begin tgt = 0; base = a - (a % (1 << PSW)); sz = 1 << PSW; end
            else if (a >= SEC_BASE) begin
              tgt = 1; sz = 1 << SSW;
              base = PRI + ((a - SEC_BASE) / sz) * sz;
            end
          end
          default: ;
        endcase
        if (tgt >= 0) begin
          if (mlock[tgt]) merr = 1;
          else for (int i = 0; i < sz; i++) pend.push_back(base + i);
        end
      end
      if (lock_set_en) begin
        if (lock_set[0]) mlock[0] = 1;
        if (lock_set[1]) mlock[1] = 1;
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      checks += 3;
      if (busy !== (pend.size() > 0)) begin
        fails++;
        $display("FAIL R11 busy actual=%0b expected=%0b t=%0t", busy, pend.size() > 0, $time);
      end
      if (err !== merr) begin
        fails++;
        $display("FAIL R9 err actual=%0b expected=%0b t=%0t", err, merr, $time);
      end
      if (rd_data !== mrd(addr, mode_hi, mode_lo)) begin
        fails++;
        $display("FAIL R5 rd_data addr=%h actual=%h expected=%h", addr, rd_data,
                 mrd(addr, mode_hi, mode_lo));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [1:0] h, input logic [1:0] l,
                           input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; mode_hi = h; mode_lo = l;
    #0.5;
    chk(tag, int'(rd_data), int'(exp));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < PRI; a++) expect_rd(16'(a), 2'b11, 2'b11, mrd(16'(a), 2'b11, 2'b11), tag);
    for (int a = SEC_BASE; a < 65536; a++)
      expect_rd(16'(a), 2'b11, 2'b11, mrd(16'(a), 2'b11, 2'b11), tag);
  endtask

  bit saw_pre, saw_busy, saw_err;
  task automatic strobe(input logic [1:0] h, input logic [1:0] l, input logic [15:0] a);
    @(negedge clk);
    mode_hi = h; mode_lo = l; addr = a; prog_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    saw_pre = busy;
    @(negedge clk);
    saw_busy = busy; saw_err = err;
    prog_n = 1'b1;
    @(negedge clk);
    mode_hi = 2'b11; mode_lo = 2'b11;
  endtask

  task automatic run_len(output int n);
    n = saw_busy ? 1 : 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic set_lock(input logic [1:0] v);
    @(negedge clk); lock_set_en = 1'b1; lock_set = v;
    @(negedge clk); lock_set_en = 1'b0; lock_set = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rst_n = 1'b0; prog_n = 1'b1; mode_hi = 2'b11; mode_lo = 2'b11;
    addr = '0; lock_set_en = 1'b0; lock_set = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    expect_rd(16'h0000, 2'b11, 2'b11, 8'h00, "R1 primary");
    expect_rd(16'hFFFF, 2'b11, 2'b11, 8'h00, "R1 secondary");
    sweep("R1 sweep");

    // R4 signature read
    expect_rd(16'h0030, 2'b00, 2'b00, 8'hBF, "R4 mfr");
    expect_rd(16'h0031, 2'b00, 2'b00, 8'hE4, "R4 dev");
    expect_rd(16'h0032, 2'b00, 2'b00, 8'h00, "R4 other");
    expect_rd(16'h4000, 2'b11, 2'b11, 8'h00, "R5 unmapped");

    // R3 signature strobe, R10 unknown code
    strobe(2'b00, 2'b00, 16'h0030);
    chk("R3 sig strobe no busy", int'(saw_busy), 0);
    strobe(2'b01, 2'b00, 16'h0000);
    chk("R10 unknown code", int'(saw_busy), 0);

    // R8 primary sector, R2 timing, R11 length
    strobe(2'b10, 2'b11, 16'h0085);
    chk("R2 not yet busy", int'(saw_pre), 0);
    chk("R2 busy at accept", int'(saw_busy), 1);
    run_len(n);
    chk("R11 primary sector length", n, 1 << PSW);
    expect_rd(16'h007F, 2'b11, 2'b11, 8'h00, "R8 below sector");
    expect_rd(16'h0080, 2'b11, 2'b11, 8'hFF, "R8 sector first");
    expect_rd(16'h00FF, 2'b11, 2'b11, 8'hFF, "R8 sector last");
    expect_rd(16'h0100, 2'b11, 2'b11, 8'h00, "R8 above sector");

    // R8 secondary sector
    strobe(2'b10, 2'b11, 16'hFF45);
    run_len(n);
    chk("R11 secondary sector length", n, 1 << SSW);
    expect_rd(16'hFF3F, 2'b11, 2'b11, 8'h00, "R8 sec below");
    expect_rd(16'hFF40, 2'b11, 2'b11, 8'hFF, "R8 sec first");
    expect_rd(16'hFF7F, 2'b11, 2'b11, 8'hFF, "R8 sec last");
    expect_rd(16'hFF80, 2'b11, 2'b11, 8'h00, "R8 sec above");

    // R7 primary region, R10 strobe while busy
    strobe(2'b11, 2'b01, 16'h0000);
    chk("R7 primary region busy", int'(saw_busy), 1);
    strobe(2'b10, 2'b11, 16'hFFC0);
    run_len(n);
    expect_rd(16'hFFC0, 2'b11, 2'b11, 8'h00, "R10 strobe while busy");
    expect_rd(16'h01FF, 2'b11, 2'b11, 8'hFF, "R7 primary last");
    expect_rd(16'h0000, 2'b11, 2'b11, 8'hFF, "R7 primary first");

    // R10 unmapped targets
    strobe(2'b11, 2'b01, 16'h8000);
    chk("R10 region unmapped", int'(saw_busy), 0);
    strobe(2'b10, 2'b11, 16'h0300);
    chk("R10 sector unmapped", int'(saw_busy), 0);
    sweep("R10 sweep");

    // R9 lock refuses secondary, primary still allowed
    set_lock(2'b10);
    strobe(2'b11, 2'b01, 16'hFF12);
    chk("R9 refused err", int'(saw_err), 1);
    chk("R9 refused busy", int'(saw_busy), 0);
    expect_rd(16'hFF00, 2'b11, 2'b11, 8'h00, "R9 array kept");
    strobe(2'b10, 2'b11, 16'hFF00);
    chk("R9 sector refused", int'(saw_err), 1);
    strobe(2'b10, 2'b11, 16'h0100);
    chk("R9 unlocked region erases", int'(saw_busy), 1);
    chk("R9 unlocked no err", int'(saw_err), 0);
    run_len(n);

    // R6 whole-array erase despite locks, locks cleared
    set_lock(2'b01);
    strobe(2'b00, 2'b01, 16'h1234);
    chk("R6 chip busy", int'(saw_busy), 1);
    run_len(n);
    chk("R11 chip length", n, TOT);
    expect_rd(16'hFF00, 2'b11, 2'b11, 8'hFF, "R6 secondary erased");
    expect_rd(16'h0000, 2'b11, 2'b11, 8'hFF, "R6 primary erased");
    sweep("R6 sweep");
    strobe(2'b11, 2'b01, 16'hFF00);
    chk("R6 locks cleared busy", int'(saw_busy), 1);
    chk("R6 locks cleared err", int'(saw_err), 0);
    run_len(n);
    chk("R11 secondary region length", n, SEC);
    chk("R7 secondary region idle", int'(busy), 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule